// File: doc/BRIEF.md
# Shared-Timebase Multi-Channel PWM Generator

This block drives a bank of pulse-width-modulated outputs from one common timebase. A programmable divider turns the system clock into a slower local tick. An 8-bit counter advances on every local tick, so a full period is always 256 local ticks long. Because every channel uses the same counter, all outputs share one period and one phase. Each channel has its own 8-bit duty value. Its output is high from the start of the period until the counter passes that value. The only way to change the period is to change the divider setting.

Software reaches the block through a 32-bit word port with a single-cycle write strobe and a combinational read-back. One control word holds the divider setting, split across two separated nibbles, and a single bit that enables all outputs together. New duty and divider values are held in a pending copy. They reach the live copy only when a period starts, so an output never sees a broken period. While the bank is disabled, the live copy follows the pending one directly, the timebase is held at zero and all outputs stay low.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every output is low, and the control word and all duty registers read 0.
- R2: Duty register n (n = 0..3) sits at byte address 4·n and holds its 8-bit value in bits 7:0. The control word sits at byte address 0x50. Address bits 1:0 are ignored. Any other word reads 0, and writes to it change nothing.
- R3: The 8-bit divider value D takes its low nibble from control bits 3:0 and its high nibble from control bits 14:11. A local tick lasts D+1 clock cycles. Control bit 9 reads back as written. All other control bits read 0.
- R4: While enabled, the period counter advances by one on each local tick and wraps from 255 to 0, so one period lasts 256·(D+1) clock cycles.
- R5: Output n is high while the period counter is at most duty n, so it is high for duty+1 local ticks at the start of each period. A duty of 0 gives a pulse of exactly one local tick.
- R6: A duty of 255 keeps the output high for the whole period, with no low cycle.
- R7: Control bit 9 enables the whole bank. While it is 0, all outputs are low and the divider and counter sit at 0. After enable rises, the first period starts at count 0 with the values that were written.
- R8: A duty or divider write made while enabled takes effect at the first period boundary after the write. A write made in the same cycle as the boundary takes effect for the period that starts at that boundary. While disabled, writes take effect at once.
- R9: All channels share one counter and one period. Each one compares only against its own duty value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word at reg_addr |
| pwm_o | output | 4 | Channel outputs |

## Verification
A wrong live duty value or a wrong counter value shows up on the outputs within one local tick, because the rising or falling edge moves. A divider that loads at the wrong time stretches or shortens the very next tick, so the output edges drift by whole cycles before the next boundary. A broken pending register is visible on the read port in the cycle after the write. The bench compares every output and the read data against a behavioural model on every clock, so any of these faults is reported in the cycle where it first becomes visible.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int unsigned BUS_W     = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned PS_W      = 8;
  localparam int unsigned PS_HALF   = PS_W / 2;
  localparam int unsigned PS_LO_LSB = 0;
  localparam int unsigned PS_HI_LSB = 11;
  localparam int unsigned EN_BIT    = 9;
  localparam int unsigned CTRL_WORD = 20;  // byte address 0x50
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DUTY_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [BUS_W-1:0]               wdata_i,
  output logic [BUS_W-1:0]               rdata_o,
  input  logic                           wrap_i,
  output logic                           en_o,
  output logic [PS_W-1:0]                ps_act_o,
  output logic [NCH-1:0][DUTY_W-1:0]     duty_act_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0]          widx;
  logic                       ctrl_hit;
  logic [NCH-1:0]             duty_hit;

  logic [PS_W-1:0]            ps_q, ps_d, ps_act_q, ps_act_d;
  logic                       en_q, en_d;
  logic [NCH-1:0][DUTY_W-1:0] duty_q, duty_d, duty_act_q, duty_act_d;
  logic                       load;

  logic unused_bits;
  assign unused_bits = ^{wdata_i, addr_i};

  assign widx     = addr_i[ADDR_W-1:2];
  assign ctrl_hit = wr_i && (widx == WIDX_W'(CTRL_WORD));

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign duty_hit[g] = wr_i && (widx == WIDX_W'(g));
  end

  // next-state: pending copy
  always_comb begin
    ps_d   = ps_q;
    en_d   = en_q;
    duty_d = duty_q;
    if (ctrl_hit) begin
      ps_d = {wdata_i[PS_HI_LSB +: PS_HALF], wdata_i[PS_LO_LSB +: PS_HALF]};
      en_d = wdata_i[EN_BIT];
    end
    for (int i = 0; i < NCH; i++) begin
      if (duty_hit[i]) duty_d[i] = wdata_i[DUTY_W-1:0];
    end
  end

  // next-state: live copy follows pending at a boundary or while idle
  assign load       = wrap_i || !en_q;
  assign ps_act_d   = ps_d;
  assign duty_act_d = duty_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q       <= '0;
      en_q       <= 1'b0;
      duty_q     <= '0;
      ps_act_q   <= '0;
      duty_act_q <= '0;
    end else begin
      if (ctrl_hit) begin
        ps_q <= ps_d;
        en_q <= en_d;
      end
      if (|duty_hit) duty_q <= duty_d;
      if (load) begin
        ps_act_q   <= ps_act_d;
        duty_act_q <= duty_act_d;
      end
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (widx == WIDX_W'(CTRL_WORD)) begin
      rdata_o[PS_LO_LSB +: PS_HALF] = ps_q[PS_HALF-1:0];
      rdata_o[PS_HI_LSB +: PS_HALF] = ps_q[PS_W-1:PS_HALF];
      rdata_o[EN_BIT]               = en_q;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (widx == WIDX_W'(i)) rdata_o[DUTY_W-1:0] = duty_q[i];
      end
    end
  end

  assign en_o       = en_q;
  assign ps_act_o   = ps_act_q;
  assign duty_act_o = duty_act_q;

  // R8: live values move only at a boundary while running
  a_r8_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && !wrap_i |=> $stable(ps_act_q) && $stable(duty_act_q));

  // R3: divider field assembly from the two nibbles
  a_r3_split_field: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_hit |=> ps_q == $past({wdata_i[PS_HI_LSB +: PS_HALF], wdata_i[PS_LO_LSB +: PS_HALF]}));

  // R7: while idle the live copy tracks pending
  a_r7_idle_track: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q && !ctrl_hit && (duty_hit == '0) |=> ps_act_q == ps_q && duty_act_q == duty_q);
endmodule

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase
  import pwm_bank_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PS_W-1:0]  ps_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [PS_W-1:0]  pcnt_q, pcnt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  assign tick   = en_i && (pcnt_q == ps_i);
  assign wrap_o = tick && (cnt_q == '1);

  always_comb begin
    pcnt_d = pcnt_q + 1'b1;
    cnt_d  = cnt_q;
    if (!en_i) begin
      pcnt_d = '0;
      cnt_d  = '0;
    end else if (tick) begin
      pcnt_d = '0;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R7: idle holds the timebase at zero
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> cnt_q == '0 && pcnt_q == '0);

  // R3: divider never exceeds its live limit while running
  a_r3_pcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> pcnt_q <= ps_i);

  // R4: counter steps by at most one, wrapping modulo the period
  a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && $past(en_i) |-> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [DUTY_W-1:0] cnt_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  assign pwm_o = en_i && (cnt_i <= duty_i);

  // R6: full-scale duty never drops low while enabled
  a_r6_full_on: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && (duty_i == '1) |-> pwm_o);

  // R7: disabled bank drives low
  a_r7_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !pwm_o);

  // R5: every period opens high
  a_r5_open_high: assert property (@(posedge clk) disable iff (!rst_n)
    en_i && (cnt_i == '0) |-> pwm_o);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned DUTY_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic [NCH-1:0]    pwm_o
);
  logic                       en;
  logic                       wrap;
  logic [PS_W-1:0]            ps_act;
  logic [NCH-1:0][DUTY_W-1:0] duty_act;
  logic [DUTY_W-1:0]          cnt;

  pwm_bank_regs #(.NCH(NCH), .DUTY_W(DUTY_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (reg_wr),
    .addr_i     (reg_addr),
    .wdata_i    (reg_wdata),
    .rdata_o    (reg_rdata),
    .wrap_i     (wrap),
    .en_o       (en),
    .ps_act_o   (ps_act),
    .duty_act_o (duty_act)
  );

  pwm_bank_timebase #(.CNT_W(DUTY_W)) u_tb (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en),
    .ps_i   (ps_act),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_bank_chan #(.DUTY_W(DUTY_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en),
      .cnt_i  (cnt),
      .duty_i (duty_act[g]),
      .pwm_o  (pwm_o[g])
    );
  end
endmodule

// File: tb/test_pwm_bank.sv
`timescale 1ns/100ps
module test_pwm_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_o;

  int vectors = 0;
  int miscompares = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  pwm_bank i_pwm_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_o(pwm_o)
  );

  // behavioural reference
  int m_ps, m_psa, m_pc, m_cnt;
  bit m_en;
  int m_duty[4];
  int m_dact[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ps = 0; m_psa = 0; m_pc = 0; m_cnt = 0; m_en = 0;
      for (int i = 0; i < 4; i++) begin m_duty[i] = 0; m_dact[i] = 0; end
    end else begin
      bit en_old, tick, wrp;
      en_old = m_en;
      tick = en_old && (m_pc == m_psa);
      wrp  = tick && (m_cnt == 255);
      if (!en_old) begin m_pc = 0; m_cnt = 0; end
      else if (tick) begin m_pc = 0; m_cnt = (m_cnt + 1) % 256; end
      else m_pc = m_pc + 1;
      if (reg_wr) begin
        if (reg_addr[7:2] == 6'd20) begin
          m_ps = {reg_wdata[14:11], reg_wdata[3:0]};
          m_en = reg_wdata[9];
        end else if (reg_addr[7:2] < 6'd4) begin
          m_duty[reg_addr[7:2]] = reg_wdata[7:0];
        end
      end
      if (!en_old || wrp) begin
        m_psa = m_ps;
        for (int i = 0; i < 4; i++) m_dact[i] = m_duty[i];
      end
    end
  end

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    logic [31:0] r = '0;
    logic [7:0] p = 8'(m_ps);
    if (a[7:2] == 6'd20) begin
      r[3:0] = p[3:0]; r[14:11] = p[7:4]; r[9] = m_en;
    end else if (a[7:2] < 6'd4) begin
      r[7:0] = 8'(m_duty[a[7:2]]);
    end
    return r;
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    logic [3:0] eo;
    logic [31:0] er;
    for (int i = 0; i < 4; i++) eo[i] = m_en && (m_cnt <= m_dact[i]);
    er = exp_rd(reg_addr);
    vectors++;
    if (pwm_o !== eo) begin
      miscompares++;
      $display("FAIL %s pwm_o t=%0t actual=%b expected=%b", cur_req, $time, pwm_o, eo);
    end
    vectors++;
    if (reg_rdata !== er) begin
      miscompares++;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", cur_req, reg_addr, reg_rdata, er);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, input int n);
    @(posedge clk); #1;
    reg_addr = a;
    repeat (n) @(posedge clk);
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(5ns * 200000);
    miscompares++;
    $display("FAIL %s watchdog actual=timeout expected=completion", cur_req);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 8'h50; reg_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state
    cur_req = "R1";
    peek(8'h50, 2); peek(8'h00, 2); peek(8'h0C, 2);
    // R2: map, readback, unmapped words
    cur_req = "R2";
    wr(8'h00, 32'hFFFF_FF00);
    wr(8'h05, 32'h0000_0001);
    wr(8'h08, 32'h0000_0080);
    wr(8'h0C, 32'h0000_00FF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h10, 32'h0000_00AA);
    peek(8'h04, 2); peek(8'h08, 2); peek(8'h0C, 2);
    peek(8'h40, 2); peek(8'h10, 2);
    // R7: disabled bank stays low
    cur_req = "R7";
    run(20);
    // R5: one-tick pulse at duty 0, duty+1 ticks elsewhere, D = 0
    cur_req = "R5";
    wr(8'h50, 32'h0000_0200);
    run(600);
    // R6: full-scale channel never low
    cur_req = "R6";
    run(300);
    // R8: duty write lands at the next boundary
    cur_req = "R8";
    wr(8'h04, 32'h0000_0040);
    run(600);
    // R3: split divider field, D = 0x13, stray bits ignored
    cur_req = "R3";
    wr(8'h50, 32'h0010_0603 | (32'h1 << 11));
    peek(8'h50, 5500);
    // R4: divider change while running, D = 2
    cur_req = "R4";
    wr(8'h50, 32'h0000_0202);
    run(7000);
    // R7: disable, write while idle, re-enable with D = 0x10
    cur_req = "R7";
    wr(8'h50, 32'h0000_0002);
    run(30);
    wr(8'h00, 32'h0000_0010);
    wr(8'h50, 32'h0000_0200 | (32'h1 << 11));
    run(5000);
    // R9: independent duties on a common counter
    cur_req = "R9";
    wr(8'h00, 32'h0000_00FE);
    wr(8'h04, 32'h0000_0000);
    wr(8'h08, 32'h0000_0007);
    wr(8'h0C, 32'h0000_0090);
    peek(8'h08, 5000);
    finish_up();
  end
endmodule